// File: doc/BRIEF.md
# Bus Low and Free Timeout Monitor

This block observes the clock and data lines of a two-wire serial bus, both already synchronized to the system clock. It produces two independent indications.

The first is an interrupt request for a clock-low timeout. A counter restarts whenever the clock line is high. It advances on clock-source ticks while the clock line is low. When it reaches a configured number of ticks, it raises a sticky request. That number would normally be chosen to equal 25 ms.

The second indication is a bus-free signal. It rises once both lines have stayed high for more than a configured number of tick periods.

The surrounding controller recovers from a timeout by disabling and re-enabling its own logic. This block only reports the condition. It counts time in tick strobes supplied from outside, so the same logic serves any clock-source rate.

Top module: `bus_idle_watch`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `low_irq` and `bus_free` are 0.
- R2: With `low_en` high, the low-timeout count advances by one on each cycle where `tick` is 1 and `scl` is 0. Cycles with `tick` 0 do not advance it. `low_irq` becomes 1 in the cycle after the clock edge that samples the `LOW_TICKS`-th such tick of one unbroken low stretch.
- R3: Any cycle with `scl` high returns the low-timeout count to zero, so a fresh low stretch again needs `LOW_TICKS` ticks.
- R4: `low_irq` stays 1 until a cycle with `low_clr` 1 or `low_en` 0. When an overflow and `low_clr` fall in the same cycle, the flag is set.
- R5: While `low_en` is 0, the count is held at zero and `low_irq` is 0 from the next cycle on.
- R6: With `free_en` high and both lines high, `bus_free` becomes 1 in the cycle after the edge that samples the `FREE_TICKS`+1-th tick of the high stretch.
- R7: `bus_free` is 0 in any cycle where `scl` or `sda` is 0, with no cycle of delay, and the free count restarts.
- R8: `bus_free` is 0 while `free_en` is 0, and the free count restarts.
- R9: Each detector depends only on its own enable. Changing `low_en` or `low_clr` does not affect `bus_free`, and `free_en` does not affect `low_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl | input | 1 | Synchronized clock line level |
| sda | input | 1 | Synchronized data line level |
| tick | input | 1 | One-cycle strobe per clock-source period |
| low_en | input | 1 | Enables the clock-low timeout detector |
| free_en | input | 1 | Enables the bus-free detector |
| low_clr | input | 1 | Clears the sticky timeout request |
| low_irq | output | 1 | Sticky clock-low timeout request |
| bus_free | output | 1 | Both lines idle high long enough |

## Verification
The bench aims at the exact tick that overflows the low counter. A design off by one would raise the request a tick early or late. It also drives a single high cycle in the middle of a low stretch; a design without the reload would fire early. It tests an overflow that coincides with a clear, where giving the clear priority would lose a timeout. On the free side, it checks the tenth and eleventh ticks, a same-cycle drop when a line falls, and restarts after the enable drops. A registered free output or a counter that only pauses would show a stale or early `bus_free`.

// File: rtl/bus_idle_pkg.sv
package bus_idle_pkg;
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/scl_low_timer.sv
module scl_low_timer
  import bus_idle_pkg::*;
#(
  parameter int unsigned LIMIT = 25000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic scl,
  input  logic tick,
  input  logic clr,
  output logic flag
);
  localparam int unsigned CW = cnt_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;
  logic          ovf;

  assign ovf = ~scl & tick & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      if (scl)       cnt <= '0;
      else if (tick) cnt <= ovf ? '0 : cnt + 1'b1;
      flag <= ovf | (flag & ~clr);
    end
  end
endmodule

// File: rtl/bus_free_detect.sv
module bus_free_detect
  import bus_idle_pkg::*;
#(
  parameter int unsigned THRESH = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic scl,
  input  logic sda,
  input  logic tick,
  output logic free
);
  localparam int unsigned FW = cnt_width(THRESH + 1);
  localparam logic [FW-1:0] TOP = FW'(THRESH);

  logic [FW-1:0] cnt;
  logic          free_q;
  logic          idle;

  assign idle = scl & sda;

  always_ff @(posedge clk) begin
    if (rst || !en || !idle) begin
      cnt    <= '0;
      free_q <= 1'b0;
    end else if (tick) begin
      if (cnt == TOP) free_q <= 1'b1;
      else            cnt    <= cnt + 1'b1;
    end
  end

  assign free = free_q & idle & en;
endmodule

// File: rtl/bus_idle_watch.sv
module bus_idle_watch #(
  parameter int unsigned LOW_TICKS  = 25000,
  parameter int unsigned FREE_TICKS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  input  logic tick,
  input  logic low_en,
  input  logic free_en,
  input  logic low_clr,
  output logic low_irq,
  output logic bus_free
);
  scl_low_timer #(.LIMIT(LOW_TICKS)) u_low (
    .clk(clk), .rst(rst), .en(low_en), .scl(scl),
    .tick(tick), .clr(low_clr), .flag(low_irq)
  );

  bus_free_detect #(.THRESH(FREE_TICKS)) u_free (
    .clk(clk), .rst(rst), .en(free_en), .scl(scl),
    .sda(sda), .tick(tick), .free(bus_free)
  );
endmodule

// File: rtl/bus_idle_watch_chk.sv
module bus_idle_watch_chk (
  input logic clk,
  input logic rst,
  input logic scl,
  input logic sda,
  input logic tick,
  input logic low_en,
  input logic free_en,
  input logic low_clr,
  input logic low_irq,
  input logic bus_free
);
  a_r1_reset_quiet: assert property (@(posedge clk) $past(rst) |-> (!low_irq && !bus_free));
  a_r2_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(low_irq) |-> $past(!scl && tick && low_en));
  a_r3_high_no_set: assert property (@(posedge clk) disable iff (rst)
    (!low_irq && scl) |=> !low_irq);
  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    (low_irq && !low_clr && low_en) |=> low_irq);
  a_r5_disable_clears: assert property (@(posedge clk) disable iff (rst)
    !low_en |=> !low_irq);
  a_r6_free_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_free) |-> $past(scl && sda && free_en));
  a_r7_line_low: assert property (@(posedge clk) disable iff (rst)
    (!scl || !sda) |-> !bus_free);
  a_r8_free_off: assert property (@(posedge clk) disable iff (rst)
    !free_en |-> !bus_free);
endmodule

bind bus_idle_watch bus_idle_watch_chk u_chk (
  .clk(clk), .rst(rst), .scl(scl), .sda(sda), .tick(tick),
  .low_en(low_en), .free_en(free_en), .low_clr(low_clr),
  .low_irq(low_irq), .bus_free(bus_free)
);

// File: tb/bus_idle_watch_bench.sv
module bus_idle_watch_bench;
  localparam int unsigned LOW  = 20;
  localparam int unsigned FREE = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1, sda = 1'b1, tick = 1'b0;
  logic low_en = 1'b0, free_en = 1'b0, low_clr = 1'b0;
  logic low_irq, bus_free;

  int checks = 0;
  int errors = 0;

  bus_idle_watch #(.LOW_TICKS(LOW), .FREE_TICKS(FREE)) u_bus_idle_watch (
    .clk(clk), .rst(rst), .scl(scl), .sda(sda), .tick(tick),
    .low_en(low_en), .free_en(free_en), .low_clr(low_clr),
    .low_irq(low_irq), .bus_free(bus_free)
  );

  always #4 clk = ~clk;

  // Reference model built from the requirements
  int m_lc = 0, m_fc = 0;
  bit m_fl = 0, m_fr = 0;
  always @(posedge clk) begin
    bit ovf;
    if (rst || !low_en) begin
      m_lc = 0; m_fl = 0;
    end else begin
      ovf = !scl && tick && (m_lc == LOW - 1);
      if (scl) m_lc = 0;
      else if (tick) m_lc = ovf ? 0 : m_lc + 1;
      m_fl = ovf || (m_fl && !low_clr);
    end
    if (rst || !free_en || !(scl && sda)) begin
      m_fc = 0; m_fr = 0;
    end else if (tick) begin
      if (m_fc == FREE) m_fr = 1;
      else m_fc = m_fc + 1;
    end
  end

  function automatic bit exp_free();
    return m_fr && scl && sda && free_en;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R2 model irq", low_irq, m_fl);
      chk("R6 model free", bus_free, exp_free());
    end
  endtask

  bit done = 0;
  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    chk("R1 irq in reset", low_irq, 1'b0);
    chk("R1 free in reset", bus_free, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    cyc();
    chk("R1 irq after reset", low_irq, 1'b0);

    // clock-low timeout at the exact tick
    low_en = 1; tick = 1; scl = 0;
    cyc(LOW - 1);
    chk("R2 no irq one tick early", low_irq, 1'b0);
    cyc();
    chk("R2 irq on last tick", low_irq, 1'b1);
    scl = 1; cyc(5);
    chk("R4 irq sticky", low_irq, 1'b1);
    low_clr = 1; cyc(); low_clr = 0;
    chk("R4 clear", low_irq, 1'b0);

    // reload on a single high cycle
    scl = 0; cyc(15); scl = 1; cyc(); scl = 0; cyc(LOW - 1);
    chk("R3 reload delays irq", low_irq, 1'b0);
    cyc();
    chk("R3 irq after fresh stretch", low_irq, 1'b1);
    low_clr = 1; scl = 1; cyc(); low_clr = 0;

    // tick gating
    scl = 0; tick = 0; cyc(40);
    chk("R2 no count without tick", low_irq, 1'b0);

    // disable clears and holds
    tick = 1; scl = 1; cyc(); scl = 0; cyc(LOW);
    chk("R2 irq again", low_irq, 1'b1);
    low_en = 0; cyc();
    chk("R5 disable clears", low_irq, 1'b0);
    cyc(30);
    chk("R5 no count while disabled", low_irq, 1'b0);

    // overflow with simultaneous clear
    low_en = 1; cyc(LOW - 1);
    low_clr = 1; cyc(); low_clr = 0;
    chk("R4 set wins over clear", low_irq, 1'b1);
    low_clr = 1; scl = 1; cyc(); low_clr = 0;

    // bus free
    free_en = 1; sda = 1; scl = 1; tick = 1;
    cyc(FREE);
    chk("R6 not free at threshold", bus_free, 1'b0);
    cyc();
    chk("R6 free after threshold", bus_free, 1'b1);
    sda = 0; #1;
    chk("R7 same-cycle drop", bus_free, 1'b0);
    cyc(); sda = 1; cyc(FREE + 1);
    chk("R7 restart count", bus_free, 1'b1);
    low_en = 0; low_clr = 1; cyc(); low_clr = 0;
    chk("R9 low side does not touch free", bus_free, 1'b1);
    free_en = 0; #1;
    chk("R8 disable drops free", bus_free, 1'b0);
    cyc(); free_en = 1; cyc(FREE);
    chk("R8 count restarted", bus_free, 1'b0);
    cyc();
    chk("R8 free again", bus_free, 1'b1);
    low_en = 1; scl = 0; cyc(LOW); free_en = 0; cyc();
    chk("R9 free side does not touch irq", low_irq, 1'b1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(15) == 0) scl = ~scl;
      if ($urandom_range(15) == 0) sda = ~sda;
      tick = ($urandom_range(1) == 0);
      low_clr = ($urandom_range(39) == 0);
      if ($urandom_range(199) == 0) low_en = ~low_en;
      if ($urandom_range(199) == 0) free_en = ~free_en;
      if ($urandom_range(499) == 0) rst = 1; else rst = 0;
      cyc();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule